// File: doc/BRIEF.md
# Transmit Swing Trim Loader

This block runs once after the PHY has been configured. It takes a 16-bit trim word from one-time-programmable storage and turns it into a transmit swing setting for the current port. It then programs that setting into the swing register of both speed banks. For each bank it issues a read, keeps the upper byte of the returned value, replaces the lower byte with the corrected trim code, and writes the result back. The first-generation bank is always handled before the second-generation bank.

The build is chosen with a parameter. The dual-port build takes a different nibble of the trim word for each combination of port and speed. The single-port build uses the lowest nibble for both banks. Each build XORs the chosen nibble with its own correction constant. The corrected 4-bit code goes into both nibbles of the low byte. If the trim word is not marked valid, the block makes no register access at all.

Register accesses leave on a valid/ready request channel. Once the request valid is high, it stays high, and address, write flag and write data stay unchanged, until ready is seen high at a clock edge. Each accepted request is answered by a single-cycle response strobe carrying read data. The response channel has no back-pressure. Start, busy and done are plain control pins.

Top module: `tx_swing_trim_loader`

## Requirements
- R1: After reset, busy, done and req_valid are all low, and no request is issued until a start is accepted.
- R2: An accepted start with a valid trim word performs exactly four accesses in this order: read of the first-generation bank, write of it, read of the second-generation bank, write of it. The swing register sits at offset 0x20. Address bit 6 selects the second-generation bank, so the four addresses are 0x20, 0x20, 0x60, 0x60.
- R3: Each write keeps bits 15:8 exactly as returned by the read of the same bank.
- R4: Bits 7:0 of each write hold the corrected 4-bit code in bits 3:0 and again in bits 7:4.
- R5: In the dual-port build, port 0 uses trim bits 3:0 for the first-generation bank and bits 7:4 for the second. Port 1 uses bits 11:8 and 15:12 in the same way.
- R6: The correction constant is 0xB in the dual-port build and 0xC in the single-port build.
- R7: The single-port build uses trim bits 3:0 for both banks and ignores the port input.
- R8: A start accepted while trim_valid is low makes no register access and leaves both swing registers unchanged. done pulses in the cycle after the start.
- R9: done is a single-cycle pulse in the cycle after the last write response. busy is high from the cycle after an accepted start until that pulse.
- R10: start is ignored while busy is high. The trim word and port in use are the ones captured when the start was accepted.
- R11: While req_valid is high and req_ready is low, req_valid, req_addr, req_write and req_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; sampled only while idle |
| trim_valid | input | 1 | The trim word holds programmed data |
| trim_word | input | 16 | One-time-programmable trim word |
| port_sel | input | 1 | Port index, used by the dual-port build only |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Single-cycle end-of-load pulse |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 7 | Register address; bit 6 selects bank |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Response strobe, one per accepted request |
| rsp_rdata | input | 16 | Read data carried with the response |

## Verification
A wrong bank or phase in the sequencer appears at the ports as a request with an unexpected address or write flag. It shows up within the next request, so the access log across one load exposes ordering faults. A stale or wrongly captured read value corrupts the upper byte of the very next write. A wrong nibble index or correction constant corrupts only the low byte, and a single-bit slip in the index is caught only by trim words whose nibbles differ, so the vectors use distinct nibbles. A sequencer that fails to return to idle shows as a missing done pulse, which the bench catches on its wait limit within a few hundred cycles.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RD_REQ  = 3'd1,
    S_RD_WAIT = 3'd2,
    S_WR_REQ  = 3'd3,
    S_WR_WAIT = 3'd4,
    S_DONE    = 3'd5
  } seq_state_t;

  localparam logic BANK_LOW  = 1'b0;
  localparam logic BANK_HIGH = 1'b1;

endpackage

// File: rtl/tsl_nibble_pick.sv
module tsl_nibble_pick #(
  parameter bit          DUAL_PORT = 1'b1,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NIB_W     = 4,
  parameter logic [3:0]  XOR_CONST = 4'hB
) (
  input  logic [WORD_W-1:0] trim_word,
  input  logic              port_sel,
  input  logic              bank,
  output logic [NIB_W-1:0]  code
);

  logic [NIB_W-1:0] raw_nib;

  generate
    if (DUAL_PORT) begin : g_dual
      logic [1:0] idx;
      assign idx = {port_sel, bank};
      always_comb begin
        raw_nib = '0;
        for (int i = 0; i < 4; i++) begin
          if (idx == 2'(i)) raw_nib = trim_word[i*NIB_W +: NIB_W];
        end
      end
      if (WORD_W > 4*NIB_W) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^trim_word[WORD_W-1:4*NIB_W];
      end
    end else begin : g_single
      logic unused_sel;
      assign unused_sel = ^{port_sel, bank, trim_word[WORD_W-1:NIB_W]};
      assign raw_nib = trim_word[NIB_W-1:0];
    end
  endgenerate

  assign code = raw_nib ^ NIB_W'(XOR_CONST);

endmodule

// File: rtl/tsl_field_merge.sv
module tsl_field_merge #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [DATA_W-1:0] read_val,
  input  logic [NIB_W-1:0]  code,
  output logic [DATA_W-1:0] write_val
);

  localparam int unsigned FIELD_W = 2 * NIB_W;

  generate
    for (genvar n = 0; n < 2; n++) begin : g_dup
      assign write_val[n*NIB_W +: NIB_W] = code;
    end
  endgenerate

  assign write_val[DATA_W-1:FIELD_W] = read_val[DATA_W-1:FIELD_W];

  logic unused_lo;
  assign unused_lo = ^read_val[FIELD_W-1:0];

endmodule

// File: rtl/tsl_sequencer.sv
module tsl_sequencer
  import tsl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter logic [5:0]  REG_OFS  = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              trim_valid,
  output logic              accept,
  output logic              bank,
  output logic              cap_read,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid
);

  seq_state_t state_q, state_d;
  logic       bank_q, bank_d;

  assign accept = (state_q == S_IDLE) && start;

  always_comb begin
    state_d = state_q;
    bank_d  = bank_q;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          bank_d  = BANK_LOW;
          state_d = trim_valid ? S_RD_REQ : S_DONE;
        end
      end
      S_RD_REQ:  if (req_ready) state_d = S_RD_WAIT;
      S_RD_WAIT: if (rsp_valid) state_d = S_WR_REQ;
      S_WR_REQ:  if (req_ready) state_d = S_WR_WAIT;
      S_WR_WAIT: begin
        if (rsp_valid) begin
          if (bank_q == BANK_LOW) begin
            bank_d  = BANK_HIGH;
            state_d = S_RD_REQ;
          end else begin
            state_d = S_DONE;
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      bank_q  <= BANK_LOW;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
    end
  end

  assign bank      = bank_q;
  assign cap_read  = (state_q == S_RD_WAIT) && rsp_valid;
  assign req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign req_write = (state_q == S_WR_REQ);
  assign req_addr  = {bank_q, REG_OFS[ADDR_W-2:0]};
  assign busy      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done      = (state_q == S_DONE);

endmodule

// File: rtl/tx_swing_trim_loader.sv
module tx_swing_trim_loader #(
  parameter bit          DUAL_PORT    = 1'b1,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned NIB_W        = 4,
  parameter logic [5:0]  SWING_OFS    = 6'h20,
  parameter logic [3:0]  XOR_DUALPORT = 4'hB,
  parameter logic [3:0]  XOR_ONEPORT  = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              trim_valid,
  input  logic [WORD_W-1:0] trim_word,
  input  logic              port_sel,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);

  localparam logic [3:0] XOR_SEL = DUAL_PORT ? XOR_DUALPORT : XOR_ONEPORT;

  logic              accept, bank, cap_read;
  logic [WORD_W-1:0] word_q;
  logic              port_q;
  logic [DATA_W-1:0] rd_q;
  logic [NIB_W-1:0]  code;

  tsl_sequencer #(
    .ADDR_W  (ADDR_W),
    .REG_OFS (SWING_OFS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .trim_valid (trim_valid),
    .accept     (accept),
    .bank       (bank),
    .cap_read   (cap_read),
    .busy       (busy),
    .done       (done),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      port_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        word_q <= trim_word;
        port_q <= port_sel;
      end
      if (cap_read) rd_q <= rsp_rdata;
    end
  end

  tsl_nibble_pick #(
    .DUAL_PORT (DUAL_PORT),
    .WORD_W    (WORD_W),
    .NIB_W     (NIB_W),
    .XOR_CONST (XOR_SEL)
  ) u_pick (
    .trim_word (word_q),
    .port_sel  (port_q),
    .bank      (bank),
    .code      (code)
  );

  tsl_field_merge #(
    .DATA_W (DATA_W),
    .NIB_W  (NIB_W)
  ) u_merge (
    .read_val  (rd_q),
    .code      (code),
    .write_val (req_wdata)
  );

endmodule

// File: rtl/tx_swing_trim_loader_chk.sv
module tx_swing_trim_loader_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned NIB_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);

  localparam int unsigned FIELD_W = 2 * NIB_W;

  logic                     rd_pend;
  logic [DATA_W-FIELD_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      hi_q    <= '0;
    end else begin
      if (req_valid && req_ready) rd_pend <= !req_write;
      if (rsp_valid && rd_pend)   hi_q    <= rsp_rdata[DATA_W-1:FIELD_W];
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata)));

  // R3
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_wdata[DATA_W-1:FIELD_W] == hi_q));

  // R4
  nibble_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_wdata[2*NIB_W-1:NIB_W] == req_wdata[NIB_W-1:0]));

  // R2
  swing_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[ADDR_W-2:0] == (ADDR_W-1)'(6'h20)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

endmodule

bind tx_swing_trim_loader tx_swing_trim_loader_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .NIB_W  (NIB_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata)
);

// File: tb/tx_swing_trim_loader_tb.sv
module tsl_reg_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic        load,
  input  logic [15:0] load_g1,
  input  logic [15:0] load_g2,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [6:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic [15:0] g1_q,
  output logic [15:0] g2_q,
  output logic [7:0]  n_acc,
  output logic [31:0] log_q
);
  assign req_ready = !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      g1_q      <= '0;
      g2_q      <= '0;
      n_acc     <= '0;
      log_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (load) begin
        g1_q  <= load_g1;
        g2_q  <= load_g2;
        log_q <= '0;
      end else if (req_valid && req_ready) begin
        rsp_valid <= 1'b1;
        n_acc     <= n_acc + 8'd1;
        log_q     <= {log_q[23:0], req_write, req_addr};
        if (req_write) begin
          if (req_addr == 7'h20) g1_q <= req_wdata;
          if (req_addr == 7'h60) g2_q <= req_wdata;
          rsp_rdata <= '0;
        end else begin
          rsp_rdata <= (req_addr == 7'h20) ? g1_q :
                       (req_addr == 7'h60) ? g2_q : 16'h0000;
        end
      end
    end
  end
endmodule

module tx_swing_trim_loader_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] FULL_LOG = 32'h20A060E0;

  typedef struct packed {
    logic        port;
    logic [15:0] word;
    logic [15:0] pre1;
    logic [15:0] pre2;
    logic [15:0] exp1;
    logic [15:0] exp2;
  } vec_t;

  // Dual-port build, correction 0xB, nibble picked by {port, bank}
  localparam vec_t VECS [4] = '{
    '{1'b0, 16'h1234, 16'hC4CC, 16'hC4EE, 16'hC4FF, 16'hC488},
    '{1'b1, 16'h1234, 16'h5A00, 16'hA5FF, 16'h5A99, 16'hA5AA},
    '{1'b0, 16'hB0B0, 16'h0000, 16'hFFFF, 16'h00BB, 16'hFF00},
    '{1'b1, 16'hFFFF, 16'h1234, 16'h8765, 16'h1244, 16'h8744}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_dp = 1'b0, start_sp = 1'b0;
  logic trim_valid = 1'b0;
  logic [15:0] trim_word = '0;
  logic port_sel = 1'b0;
  logic stall = 1'b0;
  logic load = 1'b0;
  logic [15:0] load_g1 = '0, load_g2 = '0;

  logic busy_dp, done_dp, rv_dp, rr_dp, rw_dp, sv_dp;
  logic [6:0] ra_dp;
  logic [15:0] wd_dp, rd_dp, g1_dp, g2_dp;
  logic [7:0] na_dp;
  logic [31:0] log_dp;

  logic busy_sp, done_sp, rv_sp, rr_sp, rw_sp, sv_sp;
  logic [6:0] ra_sp;
  logic [15:0] wd_sp, rd_sp, g1_sp, g2_sp;
  logic [7:0] na_sp;
  logic [31:0] log_sp;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_swing_trim_loader #(.DUAL_PORT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_dp), .trim_valid(trim_valid),
    .trim_word(trim_word), .port_sel(port_sel), .busy(busy_dp), .done(done_dp),
    .req_valid(rv_dp), .req_ready(rr_dp), .req_write(rw_dp), .req_addr(ra_dp),
    .req_wdata(wd_dp), .rsp_valid(sv_dp), .rsp_rdata(rd_dp));

  tsl_reg_model u_mdl_dp (
    .clk(clk), .rst_n(rst_n), .stall(stall), .load(load), .load_g1(load_g1),
    .load_g2(load_g2), .req_valid(rv_dp), .req_ready(rr_dp), .req_write(rw_dp),
    .req_addr(ra_dp), .req_wdata(wd_dp), .rsp_valid(sv_dp), .rsp_rdata(rd_dp),
    .g1_q(g1_dp), .g2_q(g2_dp), .n_acc(na_dp), .log_q(log_dp));

  tx_swing_trim_loader #(.DUAL_PORT(1'b0)) u_dut_sp (
    .clk(clk), .rst_n(rst_n), .start(start_sp), .trim_valid(trim_valid),
    .trim_word(trim_word), .port_sel(port_sel), .busy(busy_sp), .done(done_sp),
    .req_valid(rv_sp), .req_ready(rr_sp), .req_write(rw_sp), .req_addr(ra_sp),
    .req_wdata(wd_sp), .rsp_valid(sv_sp), .rsp_rdata(rd_sp));

  tsl_reg_model u_mdl_sp (
    .clk(clk), .rst_n(rst_n), .stall(stall), .load(load), .load_g1(load_g1),
    .load_g2(load_g2), .req_valid(rv_sp), .req_ready(rr_sp), .req_write(rw_sp),
    .req_addr(ra_sp), .req_wdata(wd_sp), .rsp_valid(sv_sp), .rsp_rdata(rd_sp),
    .g1_q(g1_sp), .g2_q(g2_sp), .n_acc(na_sp), .log_q(log_sp));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    load_g1 = a; load_g2 = b; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic pulse_start(input bit sp);
    @(negedge clk);
    if (sp) start_sp = 1'b1; else start_dp = 1'b1;
    @(negedge clk);
    start_sp = 1'b0; start_dp = 1'b0;
  endtask

  // Waits for done; then checks it drops one cycle later (R9)
  task automatic wait_done(input bit sp);
    int n = 0;
    while (!(sp ? done_sp : done_dp) && n < 300) begin
      @(negedge clk); n++;
    end
    chk("R9 done seen", 32'(sp ? done_sp : done_dp), 32'd1);
    @(negedge clk);
    chk("R9 done single pulse", 32'(sp ? done_sp : done_dp), 32'd0);
    chk("R9 busy low after done", 32'(sp ? busy_sp : busy_dp), 32'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD > 0 ? 100000 : 1) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] acc_before;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy_dp), 32'd0);
    chk("R1 done", 32'(done_dp), 32'd0);
    chk("R1 req_valid", 32'(rv_dp), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no request before start", 32'(rv_dp | rv_sp), 32'd0);

    // Vector table, dual-port build: R2 R3 R4 R5 R6
    trim_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      preload(VECS[i].pre1, VECS[i].pre2);
      trim_word = VECS[i].word;
      port_sel  = VECS[i].port;
      pulse_start(1'b0);
      chk("R9 busy after start", 32'(busy_dp), 32'd1);
      wait_done(1'b0);
      chk("R5 R6 R3 R4 gen1 bank", 32'(g1_dp), 32'(VECS[i].exp1));
      chk("R5 R6 R3 R4 gen2 bank", 32'(g2_dp), 32'(VECS[i].exp2));
      chk("R2 access order", log_dp, FULL_LOG);
    end

    // Single-port build: R7, R6 (0xC), port ignored
    preload(16'hC4CC, 16'hC4EE);
    trim_word = 16'h00A5; port_sel = 1'b1;
    pulse_start(1'b1);
    wait_done(1'b1);
    chk("R7 R6 single gen1", 32'(g1_sp), 32'h0000C499);
    chk("R7 R6 single gen2", 32'(g2_sp), 32'h0000C499);
    chk("R2 single order", log_sp, FULL_LOG);
    preload(16'h3300, 16'h77FF);
    trim_word = 16'hFFF3; port_sel = 1'b0;
    pulse_start(1'b1);
    wait_done(1'b1);
    chk("R7 single gen1 port0", 32'(g1_sp), 32'h000033FF);
    chk("R7 single gen2 port0", 32'(g2_sp), 32'h000077FF);

    // R8 skip when trim not valid
    preload(16'hABCD, 16'h1357);
    acc_before = na_dp;
    trim_valid = 1'b0; trim_word = 16'h1234; port_sel = 1'b0;
    pulse_start(1'b0);
    chk("R8 done next cycle", 32'(done_dp), 32'd1);
    chk("R8 no request", 32'(rv_dp), 32'd0);
    @(negedge clk);
    chk("R8 done pulse ends", 32'(done_dp), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 no access", 32'(na_dp), 32'(acc_before));
    chk("R8 gen1 untouched", 32'(g1_dp), 32'h0000ABCD);
    chk("R8 gen2 untouched", 32'(g2_dp), 32'h00001357);

    // R11 back-pressure and R10 start ignored while busy
    trim_valid = 1'b1;
    preload(16'hC4CC, 16'hC4EE);
    stall = 1'b1;
    trim_word = 16'h1234; port_sel = 1'b0;
    pulse_start(1'b0);
    chk("R11 request raised", 32'(rv_dp), 32'd1);
    chk("R11 first addr", 32'(ra_dp), 32'h20);
    trim_word = 16'hFFFF; port_sel = 1'b1;
    pulse_start(1'b0);
    chk("R11 valid held", 32'(rv_dp), 32'd1);
    chk("R11 addr held", 32'(ra_dp), 32'h20);
    chk("R11 read held", 32'(rw_dp), 32'd0);
    @(negedge clk);
    stall = 1'b0;
    wait_done(1'b0);
    chk("R10 gen1 from first word", 32'(g1_dp), 32'h0000C4FF);
    chk("R10 gen2 from first word", 32'(g2_dp), 32'h0000C488);
    chk("R10 single run", log_dp, FULL_LOG);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule